// File: doc/BRIEF.md
# SDRAM Command Spacing Timer

This block sits between an SDRAM command scheduler and the memory command bus. It watches single-cycle command pulses (read, write, precharge, activate) and drives a `ready` flag. The flag tells the scheduler whether a read, write or precharge may go out in the current cycle. After an accepted read or write, `ready` drops for the programmed spacing. After an accepted read, a one-cycle `rd_valid` strobe marks the cycle in which read data is expected. Each accepted read has its own strobe, so overlapping reads each get one.

All timing values come from a 32-bit configuration word. The `ddr_mode` input selects how those values are read. In single-rate operation one count is one controller clock. In double-rate operation one count is half a clock, so a value of n costs ceil(n/2) clocks. The configuration word and the mode are copied into a shadow only while nothing is in flight, so the timing of a command in progress never changes under it.

The back-pressure rule is strict. A read, write or precharge may be presented only in a cycle where `ready` is high. A command presented while `ready` is low is rejected: it is not queued, it does not restart any timer, and it raises `proto_err` for one cycle. Activate is not gated by `ready`.

Top module: `sdram_cmd_spacer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ready` is 1 and `rd_valid` and `proto_err` are 0.
- R2: The read spacing is the 4-bit field at `cfg_word[31:28]`. Let a read be accepted in cycle k, and let C(n) = n in single-rate mode and ceil(n/2) in double-rate mode. Then `ready` is low from cycle k+1 and is high again first in cycle k+max(1, C(field)).
- R3: The write spacing is the 3-bit field at `cfg_word[26:24]`. After a write is accepted in cycle k, `ready` returns high first in cycle k+max(1, C(field)), with C as in R2. A write never produces a strobe.
- R4: The read latency is the 4-bit field at `cfg_word[23:20]`. A read accepted in cycle k gives exactly one `rd_valid` pulse, in cycle k+max(1, C(field)). Reads accepted in consecutive cycles give pulses in consecutive cycles.
- R5: `ready` falls only after an accepted read or write. An accepted precharge or activate leaves `ready` high. An activate never raises `proto_err`, even while `ready` is low.
- R6: A read, write or precharge presented while `ready` is low raises `proto_err` in the next cycle. It is ignored otherwise: `ready` returns high in the same cycle it would have without it.
- R7: If two or more of the four command pulses are high in the same cycle, `proto_err` rises in the next cycle and none of them is accepted: `ready` stays high and no strobe follows.
- R8: `cfg_word` and `ddr_mode` are captured only in a cycle where `ready` is high, no strobe is pending and no command is presented. A change made while a spacing or a strobe is pending has no effect on that operation. The change applies to commands issued after the next idle cycle.
- R9: `cfg_word[27]` and `cfg_word[19:0]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | 1: counts are half-clock ticks; 0: counts are clocks |
| cfg_word | input | 32 | Timing configuration word |
| cmd_rd | input | 1 | Single read issued this cycle |
| cmd_wr | input | 1 | Single write issued this cycle |
| cmd_pre | input | 1 | Precharge issued this cycle |
| cmd_act | input | 1 | Activate issued this cycle |
| ready | output | 1 | A read, write or precharge may issue this cycle |
| rd_valid | output | 1 | Read data expected this cycle |
| proto_err | output | 1 | A command in the previous cycle broke the issue rules |

## Verification
A rejected command can land in the same cycle as a running spacing countdown, and a read strobe can fall due while `ready` is already back high and new reads are going out. The bench injects writes, precharges, activates and configuration changes part-way through a read or write gap. It then judges the outcome by the cycle in which `ready` returns and the cycle of the error flag. A run of reads in back-to-back cycles checks that the strobes stay one per read and in order. Full sweeps of every spacing and latency value in both rate modes check the arithmetic of each field.

// File: rtl/cmd_spacer_pkg.sv
package cmd_spacer_pkg;
  localparam int CFG_W   = 32;
  localparam int RD_LSB  = 28;
  localparam int RD_W    = 4;
  localparam int WR_LSB  = 24;
  localparam int WR_W    = 3;
  localparam int LAT_LSB = 20;
  localparam int LAT_W   = 4;
  localparam int TICK_W  = RD_W + 1;

  typedef struct packed {
    logic [RD_W-1:0]  rd_spc;
    logic [WR_W-1:0]  wr_spc;
    logic [LAT_W-1:0] rd_lat;
    logic             ddr;
  } timing_t;

  // Convert a programmed count into whole controller clocks, never below one.
  function automatic logic [TICK_W-1:0] ticks_to_clocks(input logic [TICK_W-1:0] t,
                                                        input logic ddr);
    logic [TICK_W-1:0] c;
    c = ddr ? ((t + TICK_W'(1)) >> 1) : t;
    return (c == '0) ? TICK_W'(1) : c;
  endfunction
endpackage

// File: rtl/spacer_cfg_latch.sv
module spacer_cfg_latch
  import cmd_spacer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ddr_mode,
  output timing_t          tm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tm <= '0;
    end else if (capture) begin
      tm.rd_spc <= cfg_word[RD_LSB +: RD_W];
      tm.wr_spc <= cfg_word[WR_LSB +: WR_W];
      tm.rd_lat <= cfg_word[LAT_LSB +: LAT_W];
      tm.ddr    <= ddr_mode;
    end
  end
endmodule

// File: rtl/spacer_gap_counter.sv
module spacer_gap_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             idle
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/spacer_rd_pipe.sv
module spacer_rd_pipe #(
  parameter int DEPTH = 15,
  localparam int DLY_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [DLY_W-1:0] delay,
  output logic             valid,
  output logic             busy
);
  logic [DEPTH-1:0] sr;
  logic [DEPTH-1:0] sr_n;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    logic upper;
    if (i == DEPTH - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = sr[i+1];
    end
    assign sr_n[i] = upper | (push && (delay == DLY_W'(i + 1)));
  end

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= sr_n;
  end

  assign valid = sr[0];
  assign busy  = |sr;
endmodule

// File: rtl/sdram_cmd_spacer.sv
module sdram_cmd_spacer
  import cmd_spacer_pkg::*;
#(
  parameter int LAT_DEPTH = (1 << LAT_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ddr_mode,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_pre,
  input  logic             cmd_act,
  output logic             ready,
  output logic             rd_valid,
  output logic             proto_err
);
  localparam int DLY_W = $clog2(LAT_DEPTH + 1);

  timing_t           tm;
  logic [2:0]        n_cmds;
  logic              multi, gated_cmd, accept, rd_go, wr_go;
  logic              pipe_busy, capture;
  logic [TICK_W-1:0] gap_ticks, gap_clk, lat_clk;
  logic              err_q;

  always_comb begin
    n_cmds    = 3'($countones({cmd_rd, cmd_wr, cmd_pre, cmd_act}));
    multi     = (n_cmds > 3'd1);
    gated_cmd = cmd_rd | cmd_wr | cmd_pre;
    accept    = ready && !multi;
    rd_go     = accept && cmd_rd;
    wr_go     = accept && cmd_wr;
    gap_ticks = rd_go ? TICK_W'(tm.rd_spc) : TICK_W'(tm.wr_spc);
    gap_clk   = ticks_to_clocks(gap_ticks, tm.ddr);
    lat_clk   = ticks_to_clocks(TICK_W'(tm.rd_lat), tm.ddr);
    capture   = ready && !pipe_busy && (n_cmds == 3'd0);
  end

  spacer_cfg_latch u_cfg (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .cfg_word (cfg_word),
    .ddr_mode (ddr_mode),
    .tm       (tm)
  );

  spacer_gap_counter #(.CNT_W(TICK_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (rd_go | wr_go),
    .load_val (gap_clk - TICK_W'(1)),
    .idle     (ready)
  );

  spacer_rd_pipe #(.DEPTH(LAT_DEPTH)) u_pipe (
    .clk   (clk),
    .rst   (rst),
    .push  (rd_go),
    .delay (DLY_W'(lat_clk)),
    .valid (rd_valid),
    .busy  (pipe_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= gated_cmd && (!ready || multi);
  end

  assign proto_err = err_q;
endmodule

// File: rtl/sdram_cmd_spacer_chk.sv
module sdram_cmd_spacer_chk (
  input logic clk,
  input logic rst,
  input logic cmd_rd,
  input logic cmd_wr,
  input logic cmd_pre,
  input logic cmd_act,
  input logic ready,
  input logic rd_valid,
  input logic proto_err
);
  logic [4:0] outstanding;
  logic       rd_acc;

  assign rd_acc = ready && cmd_rd && ($countones({cmd_rd, cmd_wr, cmd_pre, cmd_act}) == 1);

  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else     outstanding <= outstanding + 5'(rd_acc) - 5'(rd_valid);
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && !rd_valid && !proto_err));

  a_r4_strobe_has_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (outstanding != 5'd0));

  a_r5_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (ready && !cmd_rd && !cmd_wr) |=> ready);

  a_r5_act_no_err: assert property (@(posedge clk) disable iff (rst)
    (cmd_act && !cmd_rd && !cmd_wr && !cmd_pre) |=> !proto_err);

  a_r6_busy_cmd_err: assert property (@(posedge clk) disable iff (rst)
    (!ready && (cmd_rd || cmd_wr || cmd_pre)) |=> proto_err);

  a_r7_multi_err: assert property (@(posedge clk) disable iff (rst)
    ($countones({cmd_rd, cmd_wr, cmd_pre, cmd_act}) > 1) |=> (proto_err && ready));
endmodule

bind sdram_cmd_spacer sdram_cmd_spacer_chk u_chk (.*);

// File: tb/sim_sdram_cmd_spacer.sv
module sim_sdram_cmd_spacer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ddr_mode = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, cmd_act = 0;
  logic        ready, rd_valid, proto_err;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  sdram_cmd_spacer u0 (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .cfg_word(cfg_word),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .cmd_act(cmd_act),
    .ready(ready), .rd_valid(rd_valid), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clocks(input int n, input bit ddr);
    int c;
    c = ddr ? (n + 1) / 2 : n;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [31:0] mkcfg(input int rd, input int wr, input int lat, input bit junk);
    logic [31:0] w;
    w = junk ? 32'h080A_5C3B : 32'h0;
    w[31:28] = 4'(rd);
    w[26:24] = 3'(wr);
    w[23:20] = 4'(lat);
    return w;
  endfunction

  task automatic set_cfg(input bit ddr, input logic [31:0] w);
    ddr_mode = ddr;
    cfg_word = w;
    repeat (2) @(negedge clk);
  endtask

  // Issue cmd vector {rd,wr,pre,act} now; optionally inject another at cycle inj_j
  // and change the configuration at cycle 2. Watch 20 cycles.
  task automatic run(input logic [3:0] first_cmd, input int inj_j, input logic [3:0] inj_cmd,
                     input bit cfg_chg, input bit new_ddr, input logic [31:0] new_cfg,
                     output int first_rdy, output int vat, output int vcnt, output int errj);
    {cmd_rd, cmd_wr, cmd_pre, cmd_act} = first_cmd;
    @(negedge clk);
    {cmd_rd, cmd_wr, cmd_pre, cmd_act} = 4'b0;
    first_rdy = 0; vat = 0; vcnt = 0; errj = 0;
    for (int j = 1; j <= 20; j++) begin
      if (ready && first_rdy == 0) first_rdy = j;
      if (rd_valid) begin vcnt++; vat = j; end
      if (proto_err && errj == 0) errj = j;
      {cmd_rd, cmd_wr, cmd_pre, cmd_act} = (j == inj_j) ? inj_cmd : 4'b0;
      if (cfg_chg && j == 2) begin ddr_mode = new_ddr; cfg_word = new_cfg; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int fr, va, vc, ej, g, d;
    repeat (3) @(negedge clk);
    chk(ready && !rd_valid && !proto_err, "R1 in reset", {ready, rd_valid, proto_err}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(ready && !rd_valid && !proto_err, "R1 after reset", {ready, rd_valid, proto_err}, 3'b100);

    // Read spacing and latency sweep, both modes (junk in ignored bits: R9)
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 16; n++) begin
        set_cfg(m[0], mkcfg(n, 5, 15 - n, 1'b1));
        run(4'b1000, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
        g = clocks(n, m[0]);
        d = clocks(15 - n, m[0]);
        chk(fr == g, "R2 read gap", fr, g);
        chk(va == d && vc == 1, "R4 read strobe cycle", va, d);
        chk(ej == 0, "R9 no error", ej, 0);
      end
    end

    // Write spacing sweep
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 8; n++) begin
        set_cfg(m[0], mkcfg(9, n, 4, 1'b0));
        run(4'b0100, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
        g = clocks(n, m[0]);
        chk(fr == g, "R3 write gap", fr, g);
        chk(vc == 0, "R3 no strobe", vc, 0);
      end
    end

    // Ignored bits: same fields with and without junk
    set_cfg(1'b0, mkcfg(4, 2, 3, 1'b1));
    run(4'b1000, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
    chk(fr == 4 && va == 3, "R9 junk bits gap", fr, 4);

    // Precharge and activate leave ready high
    set_cfg(1'b0, mkcfg(10, 7, 3, 1'b0));
    run(4'b0010, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
    chk(fr == 1 && ej == 0, "R5 precharge", fr, 1);
    run(4'b0001, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
    chk(fr == 1 && ej == 0, "R5 activate", fr, 1);
    run(4'b1000, 2, 4'b0001, 0, 0, '0, fr, va, vc, ej);
    chk(fr == 10 && ej == 0, "R5 activate in gap", ej, 0);

    // Rejected commands during a gap
    run(4'b1000, 3, 4'b0100, 0, 0, '0, fr, va, vc, ej);
    chk(ej == 4, "R6 write in read gap err", ej, 4);
    chk(fr == 10, "R6 no reload", fr, 10);
    chk(va == 3 && vc == 1, "R6 strobe intact", va, 3);
    run(4'b0100, 5, 4'b0010, 0, 0, '0, fr, va, vc, ej);
    chk(ej == 6, "R6 precharge in write gap err", ej, 6);
    chk(fr == 7, "R6 write gap kept", fr, 7);
    run(4'b1000, 9, 4'b1000, 0, 0, '0, fr, va, vc, ej);
    chk(ej == 10 && fr == 10 && vc == 1, "R6 read at last busy cycle", ej, 10);

    // Multiple commands in one cycle
    run(4'b1100, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
    chk(ej == 1 && fr == 1 && vc == 0, "R7 read+write", ej, 1);
    run(4'b1001, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
    chk(ej == 1 && fr == 1 && vc == 0, "R7 read+activate", ej, 1);

    // Configuration change while busy
    set_cfg(1'b0, mkcfg(8, 3, 3, 1'b0));
    run(4'b1000, 0, 4'b0, 1, 0, mkcfg(2, 3, 1, 1'b0), fr, va, vc, ej);
    chk(fr == 8 && va == 3, "R8 change mid gap ignored", fr, 8);
    run(4'b1000, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
    chk(fr == 2 && va == 1, "R8 new value applied", fr, 2);
    set_cfg(1'b0, mkcfg(8, 3, 3, 1'b0));
    run(4'b1000, 0, 4'b0, 1, 1, mkcfg(8, 3, 3, 1'b0), fr, va, vc, ej);
    chk(fr == 8, "R8 mode change mid gap ignored", fr, 8);
    run(4'b1000, 0, 4'b0, 0, 0, '0, fr, va, vc, ej);
    chk(fr == 4 && va == 2, "R8 double-rate applied", fr, 4);

    // Back-to-back reads
    set_cfg(1'b0, mkcfg(1, 1, 4, 1'b0));
    begin
      int vmask;
      int rdy_low;
      vmask = 0;
      rdy_low = 0;
      cmd_rd = 1'b1;
      @(negedge clk);
      for (int j = 1; j <= 12; j++) begin
        if (rd_valid) vmask |= (1 << j);
        if (!ready) rdy_low++;
        cmd_rd = (j < 3);
        @(negedge clk);
      end
      chk(vmask == 32'h70, "R4 back-to-back strobes", vmask, 32'h70);
      chk(rdy_low == 0, "R2 unit gap keeps ready", rdy_low, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule